// File: doc/BRIEF.md
# Reconfigurable Four-Line Reversible Gate

This block applies one of the 32 positive-polarity reversible gates that can act on four data lines. The set is 4 NOT gates, 12 CNOT gates, 12 three-input Toffoli gates and 4 four-input Toffoli gates. A 5-bit configuration code picks the gate. The block has no clock: it maps a 4-bit data word, the code and three helper lines straight to outputs. Several copies are meant to be chained, each with its own code, to build a keyed substitution on four bits. Running the same chain of codes in reverse order undoes that substitution.

The network inside is a fixed cascade of controlled-swap and controlled-XOR stages over one 12-line word: 4 data lines, 5 code lines and 3 helper lines. First the code steers the chosen target line into a fixed slot. Next, each helper line becomes either a data line or a constant 1, as the code selects. A single four-input Toffoli then acts on the steered target. Last, the helper lines and the steering are undone in mirror order. Every stage is one-to-one, so the block produces no garbage lines. The code lines and the helper lines leave the block unchanged, and the outputs can feed the next copy directly.

Code layout: bits [1:0] give the target index t. Bit 2 enables data line t^1 as a control, bit 3 enables line t^2 and bit 4 enables line t^3. Zero enables gives NOT, one gives CNOT, two give a three-input Toffoli and three give a four-input Toffoli.

Top module: `nct_rev_gate`

## Requirements
- R1: With `anc_i` = 3'b111, `data_o[t]` equals `data_i[t]` XOR the AND of every enabled control line, where t = `cfg_i[1:0]` and `cfg_i[2]`, `cfg_i[3]`, `cfg_i[4]` enable data lines t^1, t^2 and t^3. An AND over no enabled lines counts as 1.
- R2: With `anc_i` = 3'b111, the three data lines other than the target leave the block unchanged.
- R3: With `anc_i` = 3'b111 and `cfg_i[4:2]` = 3'b000, the block inverts the target line (a NOT gate).
- R4: With `anc_i` = 3'b111 and `cfg_i[4:2]` = 3'b111, the target flips only when all three other data lines are 1 (a four-input Toffoli).
- R5: `cfg_o` always equals `cfg_i`.
- R6: When `anc_i` = 3'b111, `anc_o` = 3'b111 for every code and data value.
- R7: Feeding all 12 outputs into a second copy returns the original 12 inputs, for every input including `anc_i` values other than 3'b111.
- R8: The full 12-line map is one-to-one: the 4096 input words give 4096 distinct output words.
- R9: With `anc_i` = 3'b111, the 32 codes give 32 distinct functions of the data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 4 | Data word the selected gate acts on |
| cfg_i | input | 5 | Gate code: [1:0] target index, [4:2] control enables for lines t^1, t^2, t^3 |
| anc_i | input | 3 | Helper lines, held at all ones in normal use |
| data_o | output | 4 | Data word after the selected gate |
| cfg_o | output | 5 | Gate code passed through for the next copy |
| anc_o | output | 3 | Helper lines, restored to their input value |

## Verification
The bench sweeps all 4096 input words. This covers every code on every data value, and also the helper-line values that normal use never drives. A steering stage wired to the wrong pair would hit the wrong data line or scramble the lines beside the target. The bench catches that through the R1 and R2 checks and the distinct-function count. A control-generation stage with the wrong polarity or the wrong enable bit would make CNOT or Toffoli codes act as NOT, or leave a helper line at 0 on exit. The round trip through a second copy, together with the check that no output word repeats, exposes any stage that is not undone in mirror order or that loses information.

// File: rtl/nct_rev_pkg.sv
package nct_rev_pkg;

    // Position of the low member of swap pair k in the stage that acts on
    // select bit b: k with a zero inserted at bit position b.
    function automatic int pair_lo(input int b, input int k);
        int low_mask;
        low_mask = (1 << b) - 1;
        return ((k >> b) << (b + 1)) | (k & low_mask);
    endfunction

    // Partner of pair_lo across select bit b.
    function automatic int pair_hi(input int b, input int k);
        return pair_lo(b, k) + (1 << b);
    endfunction

endpackage

// File: rtl/nct_swap_cell.sv
// Controlled swap over a whole line word: when line CTRL is 1, lines LO and
// HI trade places; every other line passes straight through.
module nct_swap_cell #(
    parameter int W    = 12,
    parameter int CTRL = 0,
    parameter int LO   = 1,
    parameter int HI   = 2
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);

    always_comb begin
        word_o = word_i;
        if (word_i[CTRL]) begin
            word_o[LO] = word_i[HI];
            word_o[HI] = word_i[LO];
        end
    end

endmodule

// File: rtl/nct_xor_cell.sv
// Multi-control XOR onto one line. Lines in POS_MASK must be 1 and lines in
// NEG_MASK must be 0 for the target line TGT to invert.
module nct_xor_cell #(
    parameter int           W        = 12,
    parameter logic [W-1:0] POS_MASK = '0,
    parameter logic [W-1:0] NEG_MASK = '0,
    parameter int           TGT      = 0
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);

    logic fire;

    assign fire = (&(word_i | ~POS_MASK)) & (&(~word_i | ~NEG_MASK));

    always_comb begin
        word_o      = word_i;
        word_o[TGT] = word_i[TGT] ^ fire;
    end

endmodule

// File: rtl/nct_rev_gate.sv
// Reconfigurable reversible gate: steer, build controls, core Toffoli,
// unbuild controls, unsteer. All stages are one-to-one.
module nct_rev_gate
    import nct_rev_pkg::*;
#(
    parameter  int SEL_W  = 2,
    localparam int DATA_W = 1 << SEL_W,
    localparam int ANC_W  = DATA_W - 1,
    localparam int CODE_W = SEL_W + ANC_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CODE_W-1:0] cfg_i,
    input  logic [ANC_W-1:0]  anc_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CODE_W-1:0] cfg_o,
    output logic [ANC_W-1:0]  anc_o
);

    // Line layout inside the word.
    localparam int LINES   = DATA_W + CODE_W + ANC_W;
    localparam int DAT_LSB = 0;
    localparam int CFG_LSB = DAT_LSB + DATA_W;
    localparam int ANC_LSB = CFG_LSB + CODE_W;
    // Stage counts.
    localparam int HALF    = DATA_W / 2;
    localparam int NSW     = SEL_W * HALF;
    localparam int NCG     = ANC_W;
    localparam int GEN0    = NSW;
    localparam int CORE    = GEN0 + NCG;
    localparam int UNGEN0  = CORE + 1;
    localparam int UNSW0   = UNGEN0 + NCG;
    localparam int NST     = UNSW0 + NSW;
    localparam logic [LINES-1:0] ONE = LINES'(1);

    logic [LINES-1:0] w_d [NST+1];

    assign w_d[0] = {anc_i, cfg_i, data_i};

    // Steering: after all swaps, slot j holds data line (t XOR j).
    for (genvar s = 0; s < NSW; s++) begin : g_steer
        localparam int B = s / HALF;
        localparam int K = s % HALF;
        nct_swap_cell #(
            .W   (LINES),
            .CTRL(CFG_LSB + B),
            .LO  (DAT_LSB + pair_lo(B, K)),
            .HI  (DAT_LSB + pair_hi(B, K))
        ) u_sw (
            .word_i(w_d[s]),
            .word_o(w_d[s+1])
        );
    end

    // Control build: helper j becomes slot j+1 when enabled, else stays 1.
    for (genvar j = 0; j < NCG; j++) begin : g_gen
        localparam logic [LINES-1:0] PM = ONE << (CFG_LSB + SEL_W + j);
        localparam logic [LINES-1:0] NM = ONE << (DAT_LSB + j + 1);
        nct_xor_cell #(
            .W       (LINES),
            .POS_MASK(PM),
            .NEG_MASK(NM),
            .TGT     (ANC_LSB + j)
        ) u_cg (
            .word_i(w_d[GEN0+j]),
            .word_o(w_d[GEN0+j+1])
        );
    end

    // Core Toffoli on slot 0, controlled by every helper line.
    localparam logic [LINES-1:0] CORE_PM = ((ONE << ANC_W) - ONE) << ANC_LSB;
    nct_xor_cell #(
        .W       (LINES),
        .POS_MASK(CORE_PM),
        .NEG_MASK('0),
        .TGT     (DAT_LSB)
    ) u_core (
        .word_i(w_d[CORE]),
        .word_o(w_d[CORE+1])
    );

    // Control unbuild, mirror order.
    for (genvar j = 0; j < NCG; j++) begin : g_ungen
        localparam int G = NCG - 1 - j;
        localparam logic [LINES-1:0] PM = ONE << (CFG_LSB + SEL_W + G);
        localparam logic [LINES-1:0] NM = ONE << (DAT_LSB + G + 1);
        nct_xor_cell #(
            .W       (LINES),
            .POS_MASK(PM),
            .NEG_MASK(NM),
            .TGT     (ANC_LSB + G)
        ) u_cu (
            .word_i(w_d[UNGEN0+j]),
            .word_o(w_d[UNGEN0+j+1])
        );
    end

    // Unsteering, mirror order.
    for (genvar s = 0; s < NSW; s++) begin : g_unsteer
        localparam int S = NSW - 1 - s;
        localparam int B = S / HALF;
        localparam int K = S % HALF;
        nct_swap_cell #(
            .W   (LINES),
            .CTRL(CFG_LSB + B),
            .LO  (DAT_LSB + pair_lo(B, K)),
            .HI  (DAT_LSB + pair_hi(B, K))
        ) u_us (
            .word_i(w_d[UNSW0+s]),
            .word_o(w_d[UNSW0+s+1])
        );
    end

    assign data_o = w_d[NST][CFG_LSB-1:DAT_LSB];
    assign cfg_o  = w_d[NST][ANC_LSB-1:CFG_LSB];
    assign anc_o  = w_d[NST][LINES-1:ANC_LSB];

endmodule

module nct_rev_gate_chk #(
    parameter  int SEL_W  = 2,
    localparam int DATA_W = 1 << SEL_W,
    localparam int ANC_W  = DATA_W - 1,
    localparam int CODE_W = SEL_W + ANC_W
) (
    input logic [DATA_W-1:0] data_i,
    input logic [CODE_W-1:0] cfg_i,
    input logic [ANC_W-1:0]  anc_i,
    input logic [DATA_W-1:0] data_o,
    input logic [CODE_W-1:0] cfg_o,
    input logic [ANC_W-1:0]  anc_o
);

    logic [SEL_W-1:0] sel;
    logic [ANC_W-1:0] en;
    logic             blocked;

    assign sel = cfg_i[SEL_W-1:0];
    assign en  = cfg_i[CODE_W-1:SEL_W];

    always_comb begin
        blocked = 1'b0;
        for (int m = 1; m < DATA_W; m++) begin
            if (en[m-1] && !data_i[sel ^ SEL_W'(m)]) blocked = 1'b1;
        end
    end

    always_comb begin
        if (!$isunknown({data_i, cfg_i, anc_i, data_o, cfg_o, anc_o})) begin
            assert_cfg_thru_R5: assert (cfg_o == cfg_i)
                else $error("code lines altered");
            if (&anc_i) begin
                assert_anc_back_R6: assert (&anc_o)
                    else $error("helper lines not restored");
                assert_others_kept_R2: assert (((data_o ^ data_i) & ~(DATA_W'(1) << sel)) == '0)
                    else $error("non-target line changed");
                if (en == '0) begin
                    assert_not_flips_R3: assert (data_o[sel] != data_i[sel])
                        else $error("NOT code left target unchanged");
                end
                if (blocked) begin
                    assert_blocked_hold_R1: assert (data_o == data_i)
                        else $error("target flipped with a zero control");
                end
            end
        end
    end

endmodule

bind nct_rev_gate nct_rev_gate_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/test_nct_rev_gate.sv
module test_nct_rev_gate;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] data_i = '0;
    logic [4:0] cfg_i = '0;
    logic [2:0] anc_i = '0;
    logic [3:0] data_o, data_b;
    logic [4:0] cfg_o, cfg_b;
    logic [2:0] anc_o, anc_b;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  seen [4096];
    logic [3:0] tt [32][16];

    always #(CLK_PERIOD/2) clk = ~clk;

    nct_rev_gate i_nct_rev_gate (
        .data_i(data_i), .cfg_i(cfg_i), .anc_i(anc_i),
        .data_o(data_o), .cfg_o(cfg_o), .anc_o(anc_o)
    );

    // Second copy fed from the first, for the round trip (R7).
    nct_rev_gate i_nct_rev_gate_back (
        .data_i(data_o), .cfg_i(cfg_o), .anc_i(anc_o),
        .data_o(data_b), .cfg_o(cfg_b), .anc_o(anc_b)
    );

    task automatic check(input bit ok, input string req,
                         input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural model of the selected gate.
    function automatic logic [3:0] ref_gate(input logic [4:0] c, input logic [3:0] x);
        int t;
        logic f;
        logic [3:0] r;
        t = int'(c[1:0]);
        f = 1'b1;
        for (int m = 1; m < 4; m++) begin
            if (c[1+m]) f = f & x[t ^ m];
        end
        r = x;
        r[t] = r[t] ^ f;
        return r;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Quiet start: NOT on line 0, data zero.
        anc_i = 3'b111; cfg_i = 5'b00000; data_i = 4'b0000;
        @(negedge clk);
        check(data_o == 4'b0001, "R3 start", {8'h0, data_o}, 12'h001);
        check(anc_o == 3'b111, "R6 start", {9'h0, anc_o}, 12'h007);

        for (int v = 0; v < 4096; v++) begin
            @(posedge clk);
            data_i = v[3:0];
            cfg_i  = v[8:4];
            anc_i  = v[11:9];
            @(negedge clk);
            begin
                logic [11:0] in_w, out_w, back_w;
                logic [3:0]  exp_d;
                int          t;
                in_w   = {anc_i, cfg_i, data_i};
                out_w  = {anc_o, cfg_o, data_o};
                back_w = {anc_b, cfg_b, data_b};
                t      = int'(cfg_i[1:0]);
                check(cfg_o == cfg_i, "R5 code pass", {7'h0, cfg_o}, {7'h0, cfg_i});
                check(back_w == in_w, "R7 round trip", back_w, in_w);
                check(!seen[out_w], "R8 one-to-one", out_w, in_w);
                seen[out_w] = 1'b1;
                if (anc_i == 3'b111) begin
                    exp_d = ref_gate(cfg_i, data_i);
                    tt[cfg_i][data_i] = data_o;
                    check(data_o == exp_d, "R1 gate result", {8'h0, data_o}, {8'h0, exp_d});
                    check(((data_o ^ data_i) & ~(4'b0001 << t)) == 4'b0000, "R2 others kept",
                          {8'h0, data_o}, {8'h0, data_i});
                    check(anc_o == 3'b111, "R6 helpers restored", {9'h0, anc_o}, 12'h007);
                    if (cfg_i[4:2] == 3'b000)
                        check(data_o[t] != data_i[t], "R3 NOT", {8'h0, data_o}, {8'h0, data_i ^ (4'b0001 << t)});
                    if (cfg_i[4:2] == 3'b111) begin
                        logic all_one;
                        logic [3:0] e4;
                        all_one = 1'b1;
                        for (int m = 1; m < 4; m++) all_one = all_one & data_i[t ^ m];
                        e4 = data_i;
                        e4[t] = data_i[t] ^ all_one;
                        check(data_o == e4, "R4 four-input Toffoli", {8'h0, data_o}, {8'h0, e4});
                    end
                end
            end
        end

        begin
            int dup;
            dup = 0;
            for (int a = 0; a < 32; a++) begin
                for (int b = a + 1; b < 32; b++) begin
                    bit same;
                    same = 1'b1;
                    for (int x = 0; x < 16; x++) if (tt[a][x] !== tt[b][x]) same = 1'b0;
                    if (same) dup++;
                end
            end
            check(dup == 0, "R9 distinct functions", 12'(dup), 12'h000);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule